// File: doc/BRIEF.md
# Forty-Bit Shift, Rotate and Bit-Field Unit

This block takes a 40-bit source word and produces one 40-bit result per clock. A 3-bit operation code selects the function. There are two signed shifts, logical and arithmetic, in which the sign of the amount sets the direction. There is a rotate. There is a normalization count, which gives the number of redundant sign bits. There are two bit-field operations that use a position and a length: extract and deposit. All of the logic is combinational, and a single output register captures the result. The result is therefore visible one clock after the operands are presented.

A zero flag and an overflow flag are registered along with the result. Arithmetic units in a datapath use this block to align operands, to normalize values before rounding, and to pack or unpack narrow fields held in wide words. The width of the datapath, the insert operand, the amount and the descriptor fields are all parameters. The defaults are 40, 32, 7, 5 and 5 bits.

Top module: `shf_unit`

## Requirements
- R1: While rst_ni is low, res_o is 0, zero_o is 1 and ovf_o is 0.
- R2: Operands sampled at a rising clock edge set res_o, zero_o and ovf_o right after that edge. The outputs hold their previous values until that edge.
- R3: Opcode 0 is a logical shift. A positive amount shifts left and a negative amount shifts right. Vacated bits fill with zeros. The magnitude saturates at 40, so an amount of 40 or more in either direction gives 0.
- R4: Opcode 1 is an arithmetic shift. A positive amount shifts left with zero fill. A negative amount shifts right, and vacated bits fill with source bit 39. A right shift whose magnitude is 40 or more gives 40 copies of bit 39.
- R5: ovf_o is 1 only under opcode 1 with a positive amount, and only when bit 39 of the result differs from bit 39 of the source. In every other case ovf_o is 0.
- R6: Opcode 2 rotates. A positive amount rotates left and a negative amount rotates right, both by the saturated magnitude. A magnitude of 40 or more returns the source unchanged.
- R7: Opcode 3 counts the bits below bit 39 that equal bit 39, scanning down until the first bit that differs. The count ranges from 0 to 39 and is returned zero-extended, so a left shift by the count normalizes the source.
- R8: Opcode 4 extracts a field of len_i+1 bits that starts at bit pos_i of the source. Source bits above 39 read as 0. The field lands at bit 0. The bits above it are zeros when sx_i=0, or copies of the field's top bit when sx_i=1.
- R9: Opcode 5 deposits bits [len_i:0] of ins_i into the source starting at bit pos_i. Any insert bits that would land above bit 39 are dropped. Every other source bit passes through unchanged.
- R10: zero_o is 1 exactly when the registered result is 0.
- R11: Opcodes 6 and 7 pass the source through unchanged with ovf_o at 0, whatever the amount, position and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| src_i | input | 40 | Source word |
| ins_i | input | 32 | Insert operand for deposit |
| amt_i | input | 7 | Signed shift or rotate amount |
| pos_i | input | 5 | Field start bit |
| len_i | input | 5 | Field length minus one |
| sx_i | input | 1 | Extract mode: 1 sign-extends, 0 zero-extends |
| res_o | output | 40 | Registered result |
| zero_o | output | 1 | Registered result-is-zero flag |
| ovf_o | output | 1 | Registered arithmetic overflow flag |

## Verification
The only state in this block is the output register, so any wrong internal value shows at res_o, zero_o or ovf_o one clock after the operands that caused it. The fault is never carried forward beyond that cycle.

A faulty stage in either barrel would corrupt only the amounts whose binary code selects that stage. For that reason the full range of signed amounts is swept for every shift and rotate opcode. Faults in the length or position decoding of the field logic would show only on particular descriptors, so all 1024 position/length pairs are swept for both extract modes and for deposit.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
   typedef enum logic [2:0] {
      OP_LSH = 3'd0,
      OP_ASH = 3'd1,
      OP_ROT = 3'd2,
      OP_EXP = 3'd3,
      OP_EXT = 3'd4,
      OP_DEP = 3'd5,
      OP_RS6 = 3'd6,
      OP_RS7 = 3'd7
   } shf_op_e;
endpackage

// File: rtl/shf_barrel.sv
`timescale 1ns/1ps
// Log-stage barrel shifter; LEFT selects the direction variant.
module shf_barrel #(
   parameter int DW   = 40,
   parameter int SW   = 6,
   parameter bit LEFT = 1'b1
) (
   input  logic [DW-1:0] din,
   input  logic [SW-1:0] amt,
   input  logic          fill,
   output logic [DW-1:0] dout
);
   logic [DW-1:0] st [SW+1];

   assign st[0] = din;

   for (genvar i = 0; i < SW; i++) begin : g_stage
      localparam int SH = 1 << i;
      if (SH >= DW) begin : g_flush
         assign st[i+1] = amt[i] ? {DW{fill}} : st[i];
      end else if (LEFT) begin : g_left
         assign st[i+1] = amt[i] ? {st[i][DW-1-SH:0], {SH{fill}}} : st[i];
      end else begin : g_right
         assign st[i+1] = amt[i] ? {{SH{fill}}, st[i][DW-1:SH]} : st[i];
      end
   end

   assign dout = st[SW];
endmodule

// File: rtl/shf_expdet.sv
`timescale 1ns/1ps
// Counts sign-bit copies directly below the MSB.
module shf_expdet #(
   parameter int DW = 40,
   parameter int SW = 6
) (
   input  logic [DW-1:0] din,
   output logic [SW-1:0] cnt
);
   always_comb begin
      logic run;
      cnt = '0;
      run = 1'b1;
      for (int b = DW - 2; b >= 0; b--) begin
         if (run && (din[b] == din[DW-1])) cnt = cnt + SW'(1);
         else run = 1'b0;
      end
   end
endmodule

// File: rtl/shf_field.sv
`timescale 1ns/1ps
// Bit-field extract and deposit over a position/length descriptor.
module shf_field #(
   parameter int DW = 40,
   parameter int FW = 32,
   parameter int PW = 5,
   parameter int LW = 5
) (
   input  logic [DW-1:0] src,
   input  logic [FW-1:0] ins,
   input  logic [PW-1:0] pos,
   input  logic [LW-1:0] len,
   input  logic          sx,
   output logic [DW-1:0] ext,
   output logic [DW-1:0] dep
);
   logic [DW-1:0] wide;
   logic [DW-1:0] keep;
   logic [DW-1:0] maskd;
   logic [DW-1:0] insw;
   logic          top;

   always_comb begin
      wide = src >> pos;
      top  = wide[len];
      for (int b = 0; b < DW; b++) begin
         keep[b] = (b <= int'(len));
         ext[b]  = keep[b] ? wide[b] : (sx & top);
      end
      maskd = keep << pos;
      insw  = {{(DW-FW){1'b0}}, ins} << pos;
      dep   = (src & ~maskd) | (insw & maskd);
   end
endmodule

// File: rtl/shf_unit.sv
`timescale 1ns/1ps
module shf_unit #(
   parameter int DW = 40,
   parameter int FW = 32,
   parameter int AW = 7,
   parameter int PW = 5,
   parameter int LW = 5
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [2:0]           op_i,
   input  logic [DW-1:0]        src_i,
   input  logic [FW-1:0]        ins_i,
   input  logic signed [AW-1:0] amt_i,
   input  logic [PW-1:0]        pos_i,
   input  logic [LW-1:0]        len_i,
   input  logic                 sx_i,
   output logic [DW-1:0]        res_o,
   output logic                 zero_o,
   output logic                 ovf_o
);
   import shf_pkg::*;

   localparam int SW = $clog2(DW + 1);

   if (FW != (1 << LW)) begin : g_chk_lw
      $error("shf_unit: FW must equal 2**LW");
   end
   if (FW >= DW) begin : g_chk_fw
      $error("shf_unit: FW must be narrower than DW");
   end
   if ((1 << (AW - 1)) <= DW) begin : g_chk_aw
      $error("shf_unit: AW too narrow for a full-width amount");
   end
   if ((1 << PW) > DW) begin : g_chk_pw
      $error("shf_unit: PW addresses beyond DW");
   end

   shf_op_e       op;
   logic [AW-1:0] absv;
   logic [SW-1:0] mag, rk, la, ra;
   logic          neg, fill;
   logic [DW-1:0] lsh, rsh, extv, depv, nx;
   logic [SW-1:0] expc;
   logic          nov;

   always_comb begin
      op   = shf_op_e'(op_i);
      neg  = amt_i[AW-1];
      absv = neg ? ((~amt_i) + AW'(1)) : amt_i;
      mag  = (absv >= AW'(DW)) ? SW'(DW) : absv[SW-1:0];
      rk   = neg ? (SW'(DW) - mag) : mag;
      la   = (op == OP_ROT) ? rk : mag;
      ra   = (op == OP_ROT) ? (SW'(DW) - rk) : mag;
      fill = (op == OP_ASH) & src_i[DW-1];
   end

   shf_barrel #(.DW(DW), .SW(SW), .LEFT(1'b1)) u_lbar (
      .din(src_i), .amt(la), .fill(1'b0), .dout(lsh)
   );

   shf_barrel #(.DW(DW), .SW(SW), .LEFT(1'b0)) u_rbar (
      .din(src_i), .amt(ra), .fill(fill), .dout(rsh)
   );

   shf_expdet #(.DW(DW), .SW(SW)) u_exp (
      .din(src_i), .cnt(expc)
   );

   shf_field #(.DW(DW), .FW(FW), .PW(PW), .LW(LW)) u_fld (
      .src(src_i), .ins(ins_i), .pos(pos_i), .len(len_i), .sx(sx_i),
      .ext(extv), .dep(depv)
   );

   always_comb begin
      nov = 1'b0;
      unique case (op)
         OP_LSH:  nx = neg ? rsh : lsh;
         OP_ASH: begin
            nx  = neg ? rsh : lsh;
            nov = !neg && (lsh[DW-1] != src_i[DW-1]);
         end
         OP_ROT:  nx = lsh | rsh;
         OP_EXP:  nx = {{(DW-SW){1'b0}}, expc};
         OP_EXT:  nx = extv;
         OP_DEP:  nx = depv;
         default: nx = src_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_o  <= '0;
         zero_o <= 1'b1;
         ovf_o  <= 1'b0;
      end else begin
         res_o  <= nx;
         zero_o <= (nx == '0);
         ovf_o  <= nov;
      end
   end
endmodule

// File: rtl/shf_unit_chk.sv
`timescale 1ns/1ps
module shf_unit_chk #(
   parameter int DW = 40,
   parameter int FW = 32,
   parameter int AW = 7,
   parameter int PW = 5,
   parameter int LW = 5
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [2:0]           op_i,
   input logic [DW-1:0]        src_i,
   input logic signed [AW-1:0] amt_i,
   input logic [PW-1:0]        pos_i,
   input logic [LW-1:0]        len_i,
   input logic [DW-1:0]        res_o,
   input logic                 ovf_o
);
   import shf_pkg::*;

   logic sat;
   assign sat = (amt_i >= DW) || (amt_i <= -DW);

   AST_LSH_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_LSH && sat) |=> (res_o == '0)); // R3

   AST_OVF_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i != OP_ASH || amt_i <= 0) |=> !ovf_o); // R5

   AST_ROT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_ROT && sat) |=> (res_o == $past(src_i))); // R6

   AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_EXP) |=> (res_o < DW)); // R7

   AST_DEP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_DEP && pos_i == '0 && len_i == '1)
      |=> (res_o[DW-1:FW] == $past(src_i[DW-1:FW]))); // R9

   AST_RSV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[2:1] == 2'b11) |=> (res_o == $past(src_i) && !ovf_o)); // R11
endmodule

bind shf_unit shf_unit_chk #(.DW(DW), .FW(FW), .AW(AW), .PW(PW), .LW(LW)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .src_i(src_i),
   .amt_i(amt_i), .pos_i(pos_i), .len_i(len_i), .res_o(res_o), .ovf_o(ovf_o)
);

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;
   logic              clk_i = 1'b0;
   logic              rst_ni = 1'b0;
   logic [2:0]        op_i = '0;
   logic [39:0]       src_i = '0;
   logic [31:0]       ins_i = '0;
   logic signed [6:0] amt_i = '0;
   logic [4:0]        pos_i = '0;
   logic [4:0]        len_i = '0;
   logic              sx_i = 1'b0;
   logic [39:0]       res_o;
   logic              zero_o, ovf_o;

   int total = 0;
   int bad = 0;

   always #4 clk_i = ~clk_i;

   shf_unit u0 (
      .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .src_i(src_i), .ins_i(ins_i),
      .amt_i(amt_i), .pos_i(pos_i), .len_i(len_i), .sx_i(sx_i),
      .res_o(res_o), .zero_o(zero_o), .ovf_o(ovf_o)
   );

   function automatic void model(input int op, input logic [39:0] s,
                                 input logic [31:0] ins, input int amt,
                                 input int pos, input int len, input logic sx,
                                 output logic [39:0] r, output logic v);
      int   mag, k, idx, c;
      logic top;
      mag = (amt < 0) ? -amt : amt;
      if (mag > 40) mag = 40;
      r = '0;
      v = 1'b0;
      case (op)
         0, 1: begin
            for (int b = 0; b < 40; b++) begin
               if (amt >= 0) r[b] = (b - mag >= 0) ? s[b-mag] : 1'b0;
               else if (b + mag < 40) r[b] = s[b+mag];
               else r[b] = (op == 1) ? s[39] : 1'b0;
            end
            if (op == 1 && amt > 0 && r[39] != s[39]) v = 1'b1;
         end
         2: begin
            k = (amt < 0) ? (40 - mag) % 40 : mag % 40;
            for (int b = 0; b < 40; b++) r[b] = s[(b - k + 40) % 40];
         end
         3: begin
            c = 0;
            for (int b = 38; b >= 0; b--) begin
               if (s[b] != s[39]) break;
               c++;
            end
            r = 40'(c);
         end
         4: begin
            idx = pos + len;
            top = (idx < 40) ? s[idx] : 1'b0;
            for (int b = 0; b < 40; b++) begin
               if (b <= len) r[b] = (pos + b < 40) ? s[pos+b] : 1'b0;
               else r[b] = sx & top;
            end
         end
         5: begin
            r = s;
            for (int b = 0; b <= len; b++)
               if (pos + b < 40) r[pos+b] = ins[b];
         end
         default: r = s;
      endcase
   endfunction

   function automatic string tag_of(input int op);
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R6";
         3: return "R7";
         4: return "R8";
         5: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic run(input int op, input logic [39:0] s, input logic [31:0] ins,
                      input int amt, input int pos, input int len, input logic sx);
      logic [39:0] er;
      logic        ev;
      @(negedge clk_i);
      op_i = 3'(op); src_i = s; ins_i = ins; amt_i = 7'(amt);
      pos_i = 5'(pos); len_i = 5'(len); sx_i = sx;
      @(posedge clk_i);
      #1;
      model(op, s, ins, amt, pos, len, sx, er, ev);
      total++;
      if (res_o !== er) begin
         bad++;
         $display("FAIL %s op=%0d amt=%0d pos=%0d len=%0d sx=%0b res=%h exp=%h",
                  tag_of(op), op, amt, pos, len, sx, res_o, er);
      end
      total++;
      if (ovf_o !== ev) begin
         bad++;
         $display("FAIL R5 op=%0d amt=%0d ovf=%0b exp=%0b", op, amt, ovf_o, ev);
      end
      total++;
      if (zero_o !== (er == '0)) begin
         bad++;
         $display("FAIL R10 op=%0d zero=%0b exp=%0b", op, zero_o, (er == '0));
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      bad++;
      $display("FAIL watchdog expired res=%h exp=finished", res_o);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [39:0] pats [4];
      pats[0] = 40'h80_0000_0001;
      pats[1] = 40'h7F_FFFF_FFFE;
      pats[2] = 40'hA5_3C96_0F1E;
      pats[3] = 40'h40_0000_8000;

      // R1: reset state
      repeat (3) @(negedge clk_i);
      total++;
      if (res_o !== '0 || zero_o !== 1'b1 || ovf_o !== 1'b0) begin
         bad++;
         $display("FAIL R1 res=%h zero=%0b ovf=%0b exp=0/1/0", res_o, zero_o, ovf_o);
      end
      rst_ni = 1'b1;

      // R2: outputs hold until the sampling edge, then follow
      @(negedge clk_i);
      op_i = 3'd6; src_i = 40'h12_3456_789A; amt_i = '0;
      #1;
      total++;
      if (res_o !== '0) begin
         bad++;
         $display("FAIL R2 early res=%h exp=%h", res_o, 40'h0);
      end
      @(posedge clk_i);
      #1;
      total++;
      if (res_o !== 40'h12_3456_789A) begin
         bad++;
         $display("FAIL R2 late res=%h exp=%h", res_o, 40'h12_3456_789A);
      end

      // R3 R4 R5 R6 R10: full signed-amount sweeps
      for (int op = 0; op < 3; op++)
         for (int p = 0; p < 4; p++)
            for (int a = -64; a < 64; a++)
               run(op, pats[p], 32'h0, a, 0, 0, 1'b0);

      // R7: exponent over single-bit and inverted single-bit words
      for (int n = 0; n < 40; n++) begin
         run(3, 40'h1 << n, 32'h0, 0, 0, 0, 1'b0);
         run(3, ~(40'h1 << n), 32'h0, 0, 0, 0, 1'b0);
      end
      run(3, 40'h0, 32'h0, 0, 0, 0, 1'b0);
      run(3, '1, 32'h0, 0, 0, 0, 1'b0);

      // R8 R9: all descriptors
      for (int ps = 0; ps < 32; ps++)
         for (int ln = 0; ln < 32; ln++) begin
            run(4, 40'hC3_5A96_E71B, 32'h0, 0, ps, ln, 1'b0);
            run(4, 40'hC3_5A96_E71B, 32'h0, 0, ps, ln, 1'b1);
            run(5, 40'h5A_0F0F_F0F0, 32'h9E37_79B9, 0, ps, ln, 1'b0);
         end

      // R11: reserved opcodes ignore amount and descriptor
      for (int a = -64; a < 64; a += 9) begin
         run(6, pats[2], 32'hFFFF_FFFF, a, a & 31, 31, 1'b1);
         run(7, pats[0], 32'h0, a, 7, a & 31, 1'b0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule